// File: doc/BRIEF.md
# Serial one-time-programmable configuration PROM, programming-mode model

This block is a cycle-level model of the programming side of a one-bit-wide serial configuration PROM. A programmer drives two control inputs, a coded supply level and a clock. Once a fixed sequence has unlocked programming mode, the same pins serve four jobs. They shift a word into a set of holding latches, read the word under the word counter out bit by bit, step the word counter, or leave the mode. A separate strobe input stands in for the high-voltage programming pulse. The latched word is burned into the selected word only after enough strobes at the program level. Burning can only clear bits, so a blank cell reads as one.

The data array holds a parameterised number of rows, each of eight words of `WORD_W` bits. Two rows lie above the array. The first word of the first of them is a read-only identification word. The first word of the second holds the reset-polarity flag in its most significant bit. While the model is in programming mode, the flag is shown on `ceo`. The flag never changes how the control inputs are decoded in this mode.

Top module: `prom_pgm_model`

## Requirements
- R1: After reset the model is outside programming mode, with `data_oe` and `ceo` low. It enters only if both controls are high on each of three rising edges, with `vpp_lvl` at program (code 1) on the first two and at nominal (code 0) on the third. Any other edge restarts the sequence.
- R2: In programming mode, with both controls high, each rising edge shifts `data_in` into the latches. The bits enter least significant first, so after `WORD_W` edges the first bit loaded sits in bit 0.
- R3: Strobes are counted since the word counter last moved. A strobe counts only with `pgm_strobe` high and `vpp_lvl` at program. The selected word changes only on a counted strobe that brings the count to `NEED_STROBES` or beyond. A strobe at any other level has no effect on the count.
- R4: A committed word becomes the old contents ANDed with the latches. Bits never go from 0 to 1, and a blank word reads all ones.
- R5: The latches keep their value across strobes, reads and counter steps. An edge with a counted strobe performs no shift, read step, counter step or exit, so a retry needs no reload.
- R6: With oe low and ce high, `data_oe` is high and `data_out` shows bit 0 of the selected word at once, with no clock. Each rising edge moves on to the next bit and wraps after bit `WORD_W-1`. `data_oe` is low in every other condition.
- R7: With oe high and ce low, each rising edge advances the word counter by one. The counter stops at the polarity word address, and each step clears the strobe count.
- R8: Both controls low on a rising edge leaves programming mode, and the word counter returns to 0. The array, flag and latches keep their contents, and the full R1 sequence is needed to re-enter.
- R9: Word address 8*ROWS reads `ID_WORD`, and strobes there change nothing. Any other address above the array, other than the polarity word, reads all ones.
- R10: Word address 8*ROWS+8 reads the flag in its MSB and ones below it. A commit there ANDs the flag with latch bit `WORD_W-1`. `ceo` is high in programming mode exactly when the flag is 0.
- R11: After the flag is cleared, loading, strobing and reading data words in programming mode work exactly as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and step clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_in | input | 1 | Serial data into the latches |
| data_out | output | 1 | Serial data from the selected word |
| data_oe | output | 1 | High while the model drives the data line |
| oe_in | input | 1 | Reset/output-enable control input |
| ce_in | input | 1 | Chip-enable control input |
| vpp_lvl | input | 2 | Supply level: 0 nominal, 1 program, 2 verify |
| pgm_strobe | input | 1 | One-cycle stand-in for a programming pulse |
| ceo | output | 1 | Shows the reset-polarity flag in programming mode (high = active low) |

## Verification
The bench builds the model with `WORD_W` = 8, `ROWS` = 2 and `NEED_STROBES` = 3. With these values a word is read in eight clocks, and the identification word and the polarity word sit only 16 and 24 steps from address 0. Three strobes leave room to tell a partial count from a full one. They also show that strobes at the verify level are not counted, and that a counter step restarts the count. The values 8'hB1 and 8'h3C are loaded so that a reversed shift and an OR in place of the AND give different readbacks.

// File: rtl/prom_pgm_pkg.sv
package prom_pgm_pkg;

  typedef enum logic [1:0] {
    VPP_NOM  = 2'd0,
    VPP_PROG = 2'd1,
    VPP_VFY  = 2'd2
  } vpp_lvl_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_READ,
    OP_STEP,
    OP_EXIT
  } pgm_op_e;

endpackage

// File: rtl/prom_mode_ctrl.sv
module prom_mode_ctrl
  import prom_pgm_pkg::*;
#(
  parameter int PROG_EDGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_in,
  input  logic       ce_in,
  input  logic [1:0] vpp_lvl,
  input  logic       exit_req,
  output logic       in_mode
);

  localparam int PW = $clog2(PROG_EDGES + 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          mode_q, mode_d;
  logic          both_hi;

  assign both_hi = oe_in && ce_in;

  always_comb begin
    pcnt_d = pcnt_q;
    mode_d = mode_q;
    if (mode_q) begin
      pcnt_d = '0;
      if (exit_req) mode_d = 1'b0;
    end else if (both_hi && vpp_lvl == VPP_PROG) begin
      pcnt_d = (pcnt_q == PW'(PROG_EDGES)) ? pcnt_q : pcnt_q + 1'b1;
    end else if (both_hi && vpp_lvl == VPP_NOM && pcnt_q == PW'(PROG_EDGES)) begin
      mode_d = 1'b1;
      pcnt_d = '0;
    end else begin
      pcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      mode_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      mode_q <= mode_d;
    end
  end

  assign in_mode = mode_q;

  // R8: an exit request in mode always drops the mode on the next edge
  a_r8_exit_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && exit_req) |=> !mode_q);

  // R1: the mode is only ever entered from an edge at nominal level with both controls high
  a_r1_entry_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(vpp_lvl == VPP_NOM && oe_in && ce_in));

endmodule

// File: rtl/prom_word_path.sv
module prom_word_path
  import prom_pgm_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int AW           = 6,
  parameter int LAST_ADDR    = 40,
  parameter int NEED_STROBES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_mode,
  input  pgm_op_e           op,
  input  logic              rd_cond,
  input  logic              strobe_ok,
  input  logic              data_in,
  output logic [WORD_W-1:0] latch_q,
  output logic [AW-1:0]     addr_q,
  output logic [$clog2(WORD_W)-1:0] bidx_q,
  output logic              commit
);

  localparam int BW = $clog2(WORD_W);
  localparam int SW = $clog2(NEED_STROBES + 1);

  logic [WORD_W-1:0] latch_d;
  logic [AW-1:0]     addr_d;
  logic [BW-1:0]     bidx_d;
  logic [SW-1:0]     scnt_q, scnt_d;
  logic              latch_en;

  assign latch_en = (op == OP_LOAD);
  assign latch_d  = {data_in, latch_q[WORD_W-1:1]};
  assign commit   = strobe_ok && (scnt_q >= SW'(NEED_STROBES - 1));

  always_comb begin
    addr_d = addr_q;
    if (!in_mode)
      addr_d = '0;
    else if (op == OP_STEP && addr_q != AW'(LAST_ADDR))
      addr_d = addr_q + 1'b1;
  end

  always_comb begin
    bidx_d = bidx_q;
    if (!rd_cond)
      bidx_d = '0;
    else if (op == OP_READ)
      bidx_d = (bidx_q == BW'(WORD_W - 1)) ? '0 : bidx_q + 1'b1;
  end

  always_comb begin
    scnt_d = scnt_q;
    if (!in_mode || op == OP_STEP)
      scnt_d = '0;
    else if (strobe_ok && scnt_q != SW'(NEED_STROBES))
      scnt_d = scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      addr_q  <= '0;
      bidx_q  <= '0;
      scnt_q  <= '0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      addr_q <= addr_d;
      bidx_q <= bidx_d;
      scnt_q <= scnt_d;
    end
  end

  // R7: the word counter never passes the polarity word
  a_r7_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= AW'(LAST_ADDR));

  // R6: a new read always starts on bit 0
  a_r6_read_from_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_cond) |-> (bidx_q == '0));

  // R5: latches hold whenever the previous edge carried no load
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op == OP_LOAD) |-> $stable(latch_q));

endmodule

// File: rtl/prom_cell_store.sv
module prom_cell_store #(
  parameter int              WORD_W     = 32,
  parameter int              DATA_WORDS = 32,
  parameter int              AW         = 6,
  parameter int              ID_ADDR    = 32,
  parameter int              POL_ADDR   = 40,
  parameter logic [WORD_W-1:0] ID_WORD  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              commit,
  input  logic [WORD_W-1:0] latch_q,
  output logic [WORD_W-1:0] rd_word,
  output logic              pol_flag
);

  localparam int IW = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;

  logic [WORD_W-1:0] cells_q [DATA_WORDS];
  logic              flag_q, flag_en;

  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_word
    logic wr_en;
    assign wr_en = commit && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells_q[g] <= '1;
      else if (wr_en)
        cells_q[g] <= cells_q[g] & latch_q;
    end
  end

  assign flag_en = commit && (addr == AW'(POL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b1;
    else if (flag_en)
      flag_q <= flag_q & latch_q[WORD_W-1];
  end

  always_comb begin
    if (addr < AW'(DATA_WORDS))
      rd_word = cells_q[addr[IW-1:0]];
    else if (addr == AW'(ID_ADDR))
      rd_word = ID_WORD;
    else if (addr == AW'(POL_ADDR))
      rd_word = {flag_q, {(WORD_W-1){1'b1}}};
    else
      rd_word = '1;
  end

  assign pol_flag = flag_q;

  // R4: while the address holds, no bit of the selected word rises
  a_r4_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr) |-> ((rd_word & ~$past(rd_word)) == '0));

  // R3: without a commit the selected word is unchanged
  a_r3_quiet_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(addr) && !$past(commit)) |-> $stable(rd_word));

  // R10: the flag is one-way
  a_r10_flag_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(flag_q));

endmodule

// File: rtl/prom_pgm_model.sv
module prom_pgm_model
  import prom_pgm_pkg::*;
#(
  parameter int              WORD_W       = 32,
  parameter int              ROWS         = 4,
  parameter int              NEED_STROBES = 2,
  parameter logic [WORD_W-1:0] ID_WORD    = {(WORD_W/8){8'h5A}}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_in,
  output logic       data_out,
  output logic       data_oe,
  input  logic       oe_in,
  input  logic       ce_in,
  input  logic [1:0] vpp_lvl,
  input  logic       pgm_strobe,
  output logic       ceo
);

  localparam int WORDS_PER_ROW = 8;
  localparam int DATA_WORDS    = ROWS * WORDS_PER_ROW;
  localparam int ID_ADDR       = DATA_WORDS;
  localparam int POL_ADDR      = DATA_WORDS + WORDS_PER_ROW;
  localparam int AW            = $clog2(POL_ADDR + 1);
  localparam int BW            = $clog2(WORD_W);

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic              in_mode, strobe_ok, rd_cond, exit_req, commit, pol_flag;
  pgm_op_e           op;
  logic [WORD_W-1:0] latch_q, rd_word;
  logic [AW-1:0]     addr_q;
  logic [BW-1:0]     bidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign strobe_ok = in_mode && pgm_strobe && (vpp_lvl == VPP_PROG);
  assign rd_cond   = in_mode && !oe_in && ce_in;

  always_comb begin
    op = OP_NONE;
    if (in_mode && !strobe_ok) begin
      case ({oe_in, ce_in})
        2'b11:   op = OP_LOAD;
        2'b01:   op = OP_READ;
        2'b10:   op = OP_STEP;
        default: op = OP_EXIT;
      endcase
    end
  end

  assign exit_req = (op == OP_EXIT);

  prom_mode_ctrl #(.PROG_EDGES(2)) u_mode (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .oe_in    (oe_in),
    .ce_in    (ce_in),
    .vpp_lvl  (vpp_lvl),
    .exit_req (exit_req),
    .in_mode  (in_mode)
  );

  prom_word_path #(
    .WORD_W       (WORD_W),
    .AW           (AW),
    .LAST_ADDR    (POL_ADDR),
    .NEED_STROBES (NEED_STROBES)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_mode   (in_mode),
    .op        (op),
    .rd_cond   (rd_cond),
    .strobe_ok (strobe_ok),
    .data_in   (data_in),
    .latch_q   (latch_q),
    .addr_q    (addr_q),
    .bidx_q    (bidx_q),
    .commit    (commit)
  );

  prom_cell_store #(
    .WORD_W     (WORD_W),
    .DATA_WORDS (DATA_WORDS),
    .AW         (AW),
    .ID_ADDR    (ID_ADDR),
    .POL_ADDR   (POL_ADDR),
    .ID_WORD    (ID_WORD)
  ) u_cells (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr     (addr_q),
    .commit   (commit),
    .latch_q  (latch_q),
    .rd_word  (rd_word),
    .pol_flag (pol_flag)
  );

  assign data_oe  = rd_cond;
  assign data_out = rd_cond ? rd_word[bidx_q] : 1'b0;
  assign ceo      = in_mode && !pol_flag;

  // R6: the data line is never driven while the controls ask for a load
  a_r6_no_drive_on_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (oe_in && ce_in) |-> !data_oe);

  // R10: ceo is silent outside programming mode
  a_r10_ceo_only_in_mode: assert property (@(posedge clk) disable iff (!rst_int_n)
    ceo |-> data_oe || oe_in || !ce_in);

endmodule

// File: tb/tb_prom_pgm_model.sv
module tb_prom_pgm_model;

  localparam int W = 8;
  localparam logic [1:0] NOM = 2'd0, PRG = 2'd1, VFY = 2'd2;

  logic clk, rst_n, din, dout, doe, oe, ce, stb, ceo;
  logic [1:0] vpp;
  int n_chk, n_bad;
  bit done;

  prom_pgm_model #(.WORD_W(W), .ROWS(2), .NEED_STROBES(3), .ID_WORD(8'hB4)) dut (
    .clk(clk), .rst_n(rst_n), .data_in(din), .data_out(dout), .data_oe(doe),
    .oe_in(oe), .ce_in(ce), .vpp_lvl(vpp), .pgm_strobe(stb), .ceo(ceo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic setin(input logic o, input logic c, input logic [1:0] v, input logic s);
    oe = o; ce = c; vpp = v; stb = s;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enter_mode();
    setin(1, 1, PRG, 0); tick(); tick();
    setin(1, 1, NOM, 0); tick();
  endtask

  task automatic exit_mode();
    setin(0, 0, NOM, 0); tick();
  endtask

  task automatic load_word(input logic [7:0] w);
    for (int i = 0; i < W; i++) begin
      din = w[i];
      setin(1, 1, NOM, 0);
      tick();
    end
    din = 1'b0;
  endtask

  task automatic strobes(input int n);
    din = 1'b0;
    setin(1, 1, PRG, 1);
    repeat (n) tick();
    setin(1, 1, NOM, 0);
  endtask

  task automatic steps(input int n);
    setin(1, 0, NOM, 0);
    repeat (n) tick();
  endtask

  task automatic read_word(input logic [1:0] v, input logic s, output logic [7:0] w);
    setin(0, 1, v, s);
    for (int i = 0; i < W; i++) begin
      #1 w[i] = dout;
      tick();
    end
    stb = 1'b0;
  endtask

  task automatic probe_mode(input string req, input logic exp_oe, input logic exp_ceo);
    setin(0, 1, NOM, 0);
    #1;
    chk(req, doe, exp_oe);
    chk(req, ceo, exp_ceo);
  endtask

  task automatic t_reset_and_entry();
    probe_mode("R1 reset state", 0, 0);
    setin(1, 1, PRG, 0); tick();
    setin(1, 1, NOM, 0); tick();
    probe_mode("R1 one program edge only", 0, 0);
    setin(1, 1, PRG, 0); tick(); tick();
    setin(1, 1, VFY, 0); tick();
    probe_mode("R1 verify level as third edge", 0, 0);
    enter_mode();
    probe_mode("R1 entered", 1, 0);
  endtask

  task automatic t_load_commit();
    logic [7:0] r;
    read_word(NOM, 0, r);
    chk("R6 blank word reads ones", r, 8'hFF);
    setin(1, 1, NOM, 0); #1;
    chk("R6 no drive during load", doe, 0);
    load_word(8'hB1);
    strobes(2);
    read_word(NOM, 0, r);
    chk("R3 two strobes no commit", r, 8'hFF);
    read_word(VFY, 1, r);
    chk("R3 verify-level strobes ignored", r, 8'hFF);
    strobes(1);
    read_word(NOM, 0, r);
    chk("R2 R3 committed lsb-first word", r, 8'hB1);
    load_word(8'h3C);
    strobes(1);
    read_word(NOM, 0, r);
    chk("R4 and of old and latch", r, 8'h30);
  endtask

  task automatic t_retry_and_count();
    logic [7:0] r;
    steps(1);
    strobes(3);
    read_word(NOM, 0, r);
    chk("R5 latch kept, no reload", r, 8'h3C);
    steps(1);
    load_word(8'h81);
    strobes(2);
    steps(1);
    strobes(1);
    read_word(NOM, 0, r);
    chk("R7 step clears strobe count", r, 8'hFF);
  endtask

  task automatic t_hidden_rows();
    logic [7:0] r;
    steps(13);
    read_word(NOM, 0, r);
    chk("R9 id word", r, 8'hB4);
    strobes(3);
    read_word(NOM, 0, r);
    chk("R9 id word unchanged by strobes", r, 8'hB4);
    steps(1);
    read_word(NOM, 0, r);
    chk("R9 spare hidden word reads ones", r, 8'hFF);
    steps(7);
    read_word(NOM, 0, r);
    chk("R10 blank polarity word", r, 8'hFF);
    probe_mode("R10 ceo low while flag is one", 1, 0);
    load_word(8'h7F);
    strobes(3);
    read_word(NOM, 0, r);
    chk("R10 polarity word after clear", r, 8'h7F);
    probe_mode("R10 ceo high after clear", 1, 1);
    steps(3);
    read_word(NOM, 0, r);
    chk("R7 counter stops at polarity word", r, 8'h7F);
  endtask

  task automatic t_exit_reenter();
    logic [7:0] r;
    exit_mode();
    probe_mode("R8 exited", 0, 0);
    setin(1, 1, NOM, 0); tick();
    probe_mode("R8 no re-entry without sequence", 0, 0);
    enter_mode();
    probe_mode("R8 R10 re-entered, flag kept", 1, 1);
    read_word(NOM, 0, r);
    chk("R8 counter back at 0, array kept", r, 8'h30);
    steps(4);
    load_word(8'h55);
    strobes(3);
    read_word(NOM, 0, r);
    chk("R11 data path unaffected by flag", r, 8'h55);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; din = 1'b0;
    setin(0, 0, NOM, 0);
    tick(); tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset_and_entry();
    t_load_commit();
    t_retry_and_count();
    t_hidden_rows();
    t_exit_reenter();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule